// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

A register-mapped bank of general-purpose pins, sized by a parameter of up to 32 pins. Software drives an output value and an output-enable mask, and reads the pin levels after a two-stage synchroniser. Each pin also has an interrupt detector. A per-pin trigger-type bit selects edge or level sensing, and a per-pin polarity bit selects the active direction. Detected conditions set sticky pending bits. Software clears these bits by writing ones. The pending bits, masked by a per-pin enable, combine into one summary interrupt line.

Edge and level sources are both latched. No mode catches both edges. Software emulates it by rewriting a pin's polarity to the inverse of its present level after each event. For this reason a polarity change on a steady pin must never create an edge event. Register reads are combinational from the current address. A write takes effect at the rising clock edge on which the write strobe is high.

Top module: `gpio_bank`

## Requirements
- R1: After reset the output, output-enable, trigger-type, enable and status registers are 0. Polarity is all ones across the implemented pins, and irq_o is 0.
- R2: The output register (offset 0x00) and the output-enable register (offset 0x10) store the written bits for the implemented pins. They read back those bits and drive pin_out_o and pin_oe_o from the edge after the write.
- R3: The input register (offset 0x34) reads 0 one edge after a pin change and the new pin value after the second rising edge. It is read-only, so writes to it change nothing.
- R4: With trigger-type bit 1 (offset 0x60), polarity bit 1 (offset 0x70) detects a rising edge and polarity bit 0 detects a falling edge. The status bit reads 1 after the third rising clock edge following the pin change, and not after the second.
- R5: With trigger-type bit 0, the pin's status bit is set whenever its synchronised level equals the polarity bit (1 = active high, 0 = active low). The bit stays 1 after the level goes inactive, until it is cleared.
- R6: Writing 1 to a bit of the clear register (offset 0x90) clears that status bit. Zero bits leave status unchanged, and the clear register reads 0.
- R7: When a detection event and a clear of the same bit fall on the same edge, the status bit ends at 1. A level source that is still active stays pending through a clear.
- R8: In edge mode, rewriting the polarity of a pin whose level is steady does not set its status bit.
- R9: irq_o is 1 exactly when some bit of status (offset 0xA0) and the same bit of enable (offset 0x80) are both 1.
- R10: Offsets outside the eight registers read 0, and writes to them change nothing. Bits at and above the pin count read 0 in every register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register byte offset |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pin_i | input | NPINS | Asynchronous pin levels |
| pin_out_o | output | NPINS | Output value to pad drivers |
| pin_oe_o | output | NPINS | Output enable to pad drivers |
| irq_o | output | 1 | Summary interrupt |

## Verification
The assertions check several rules on every cycle. An event always leaves its status bit set, and status bits fall only under a clear write. A bit newly set in edge mode needs a change of the synchronised pin. irq_o needs a nonzero enable, the clear register and the unused upper bits read 0, and the output register holds without a write. Other behaviour can only be shown by the bench's scenarios: the exact three-edge detection latency, the polarity meaning in both modes, level re-latching through a clear, and the read-only input register. The bench also runs a randomised mix of writes, clears and pin toggles against a cycle-level reference model.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  // Byte offsets decoded by software
  localparam logic [ADDR_W-1:0] OFS_OUT  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_OE   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_IN   = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_TRIG = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_POL  = 8'h70;
  localparam logic [ADDR_W-1:0] OFS_EN   = 8'h80;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 8'h90;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'hA0;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int NPINS = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] sync_o,
  output logic [NPINS-1:0] prev_o
);
  logic [NPINS-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
  parameter int NPINS = 27
) (
  input  logic [NPINS-1:0] cur_i,
  input  logic [NPINS-1:0] prev_i,
  input  logic [NPINS-1:0] edge_mode_i,
  input  logic [NPINS-1:0] pol_i,
  output logic [NPINS-1:0] event_o
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic rise, fall, lvl_hit, edge_hit;
    assign rise     = cur_i[i] & ~prev_i[i];
    assign fall     = ~cur_i[i] & prev_i[i];
    assign lvl_hit  = pol_i[i] ? cur_i[i] : ~cur_i[i];
    assign edge_hit = pol_i[i] ? rise : fall;
    assign event_o[i] = edge_mode_i[i] ? edge_hit : lvl_hit;
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 27
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NPINS-1:0]  sync_i,
  input  logic [NPINS-1:0]  event_i,
  output logic [NPINS-1:0]  out_q,
  output logic [NPINS-1:0]  oe_q,
  output logic [NPINS-1:0]  trig_q,
  output logic [NPINS-1:0]  pol_q,
  output logic [NPINS-1:0]  en_q,
  output logic [NPINS-1:0]  status_q
);
  logic [NPINS-1:0] wbits, clr_bits;

  assign wbits    = wdata_i[NPINS-1:0];
  assign clr_bits = (wr_i && addr_i == OFS_CLR) ? wbits : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      oe_q   <= '0;
      trig_q <= '0;
      pol_q  <= '1;
      en_q   <= '0;
    end else if (wr_i) begin
      case (addr_i)
        OFS_OUT:  out_q  <= wbits;
        OFS_OE:   oe_q   <= wbits;
        OFS_TRIG: trig_q <= wbits;
        OFS_POL:  pol_q  <= wbits;
        OFS_EN:   en_q   <= wbits;
        default:  ;
      endcase
    end
  end

  // New event outranks a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_bits) | event_i;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_OUT:  rdata_o[NPINS-1:0] = out_q;
      OFS_OE:   rdata_o[NPINS-1:0] = oe_q;
      OFS_IN:   rdata_o[NPINS-1:0] = sync_i;
      OFS_TRIG: rdata_o[NPINS-1:0] = trig_q;
      OFS_POL:  rdata_o[NPINS-1:0] = pol_q;
      OFS_EN:   rdata_o[NPINS-1:0] = en_q;
      OFS_STAT: rdata_o[NPINS-1:0] = status_q;
      default:  ;
    endcase
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 27
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_out_o,
  output logic [NPINS-1:0]  pin_oe_o,
  output logic              irq_o
);
  logic [NPINS-1:0] sync_w, prev_w, event_w;
  logic [NPINS-1:0] trig_q, pol_q, en_q, status_q;

  gpio_sync #(.NPINS(NPINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .sync_o (sync_w),
    .prev_o (prev_w)
  );

  gpio_trig_detect #(.NPINS(NPINS)) u_detect (
    .cur_i       (sync_w),
    .prev_i      (prev_w),
    .edge_mode_i (trig_q),
    .pol_i       (pol_q),
    .event_o     (event_w)
  );

  gpio_bank_regs #(.NPINS(NPINS)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wr_i     (wr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .sync_i   (sync_w),
    .event_i  (event_w),
    .out_q    (pin_out_o),
    .oe_q     (pin_oe_o),
    .trig_q   (trig_q),
    .pol_q    (pol_q),
    .en_q     (en_q),
    .status_q (status_q)
  );

  assign irq_o = |(status_q & en_q);
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 27
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [NPINS-1:0]  pin_out_o,
  input logic              irq_o,
  input logic [NPINS-1:0]  status_q,
  input logic [NPINS-1:0]  en_q,
  input logic [NPINS-1:0]  trig_q,
  input logic [NPINS-1:0]  event_w,
  input logic [NPINS-1:0]  sync_w,
  input logic [NPINS-1:0]  prev_w
);
  localparam logic [DATA_W-1:0] PIN_MASK = DATA_W'({NPINS{1'b1}});

  AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|event_w) |=> ((status_q & $past(event_w)) == $past(event_w))); // R7

  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == OFS_CLR) |=> ((status_q & $past(status_q)) == $past(status_q))); // R5

  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_CLR) |=>
      ((status_q & $past(wdata_i[NPINS-1:0]) & ~$past(event_w)) == '0)); // R6

  AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> ((status_q & ~$past(status_q) & $past(trig_q)
                 & ~($past(sync_w) ^ $past(prev_w))) == '0)); // R8

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|en_q)); // R9

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == OFS_OUT) |=> $stable(pin_out_o)); // R2

  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~PIN_MASK) == '0); // R10

  AST_CLR_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFS_CLR) |-> (rdata_o == '0)); // R6
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_i      (wr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .pin_out_o (pin_out_o),
  .irq_o     (irq_o),
  .status_q  (status_q),
  .en_q      (en_q),
  .trig_q    (trig_q),
  .event_w   (event_w),
  .sync_w    (sync_w),
  .prev_w    (prev_w)
);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  import gpio_bank_pkg::*;

  localparam int  NP = 27;
  localparam time CLK_PERIOD = 10;
  localparam logic [31:0] MASK = (32'h1 << NP) - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [7:0]    addr_i = '0;
  logic          wr_i = 1'b0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [NP-1:0] pin_i = '0;
  logic [NP-1:0] pin_out_o, pin_oe_o;
  logic          irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  gpio_bank #(.NPINS(NP)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_i(pin_i),
    .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // Reference model of the register-level behaviour
  logic [31:0] m_out, m_oe, m_trig, m_pol, m_en, m_stat, m_s1, m_s2, m_prev;

  function automatic logic [31:0] model_event();
    logic [31:0] edg, lvl;
    edg = (m_pol & m_s2 & ~m_prev) | (~m_pol & ~m_s2 & m_prev);
    lvl = (m_pol & m_s2) | (~m_pol & ~m_s2);
    return ((m_trig & edg) | (~m_trig & lvl)) & MASK;
  endfunction

  function automatic logic [31:0] model_read(logic [7:0] a);
    case (a)
      OFS_OUT:  return m_out;
      OFS_OE:   return m_oe;
      OFS_IN:   return m_s2;
      OFS_TRIG: return m_trig;
      OFS_POL:  return m_pol;
      OFS_EN:   return m_en;
      OFS_STAT: return m_stat;
      default:  return 32'h0;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_out = '0; m_oe = '0; m_trig = '0; m_pol = MASK; m_en = '0;
      m_stat = '0; m_s1 = '0; m_s2 = '0; m_prev = '0;
    end else begin
      logic [31:0] ev, clr, wd;
      ev  = model_event();
      wd  = wdata_i & MASK;
      clr = (wr_i && addr_i == OFS_CLR) ? wd : 32'h0;
      m_stat = (m_stat & ~clr) | ev;
      if (wr_i) begin
        case (addr_i)
          OFS_OUT:  m_out  = wd;
          OFS_OE:   m_oe   = wd;
          OFS_TRIG: m_trig = wd;
          OFS_POL:  m_pol  = wd;
          OFS_EN:   m_en   = wd;
          default:  ;
        endcase
      end
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = 32'(pin_i);
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
    addr_i = a;
    #1;
    chk(req, $sformatf("read @%h", a), rdata_o, exp);
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] addrs [10];
    addrs = '{OFS_OUT, OFS_OE, OFS_IN, OFS_TRIG, OFS_POL, OFS_EN, OFS_CLR, OFS_STAT, 8'h04, 8'hFC};
    void'($urandom(32'd20240611));
    cycles(3);
    rst_ni = 1'b1;
    cycles(2);

    // R1 reset state
    rd("R1", OFS_OUT, 0); rd("R1", OFS_OE, 0); rd("R1", OFS_TRIG, 0);
    rd("R1", OFS_POL, MASK); rd("R1", OFS_EN, 0); rd("R1", OFS_STAT, 0);
    chk("R1", "irq_o", 32'(irq_o), 0);

    // R2 output and output enable
    wr(OFS_OUT, 32'hFFFF_FFFF);
    rd("R2", OFS_OUT, MASK);
    chk("R2", "pin_out_o", 32'(pin_out_o), MASK);
    wr(OFS_OE, 32'h8123_4567);
    rd("R2", OFS_OE, 32'h8123_4567 & MASK);
    chk("R2", "pin_oe_o", 32'(pin_oe_o), 32'h8123_4567 & MASK);

    // R10 unmapped offset
    wr(8'h04, 32'hFFFF_FFFF);
    rd("R10", 8'h04, 0);
    rd("R10", OFS_OUT, MASK);
    wr(8'hFC, 32'h0);
    rd("R10", OFS_OE, 32'h8123_4567 & MASK);

    // R3 synchronised input, read-only
    @(negedge clk_i); pin_i = 27'h5A5_A5A5;
    @(negedge clk_i); rd("R3", OFS_IN, 0);
    @(negedge clk_i); rd("R3", OFS_IN, 32'h05A5_A5A5);
    wr(OFS_IN, 32'h0);
    rd("R3", OFS_IN, 32'h05A5_A5A5);

    // R5 level sources latch (reset: level mode, active high)
    pin_i = '0;
    cycles(4);
    rd("R5", OFS_STAT, 32'h05A5_A5A5);
    wr(OFS_CLR, 32'hFFFF_FFFF);
    rd("R6", OFS_STAT, 0);
    rd("R6", OFS_CLR, 0);

    // R6 zero bits do not clear
    pin_i = 27'h1; cycles(4); pin_i = '0; cycles(4);
    wr(OFS_CLR, 32'hFFFF_FFFE);
    rd("R6", OFS_STAT, 1);
    wr(OFS_CLR, 32'h1);
    rd("R6", OFS_STAT, 0);

    // R5 active-low level on pin 3
    wr(OFS_POL, MASK & ~32'h8);
    cycles(1);
    rd("R5", OFS_STAT, 32'h8);
    wr(OFS_POL, MASK);
    wr(OFS_CLR, MASK);
    rd("R5", OFS_STAT, 0);

    // R4 edge mode: pin1 rising, pin2 falling
    wr(OFS_TRIG, MASK);
    wr(OFS_POL, MASK & ~32'h4);
    @(negedge clk_i); pin_i = 27'h6;
    @(negedge clk_i);
    @(negedge clk_i); rd("R4", OFS_STAT, 0);
    @(negedge clk_i); rd("R4", OFS_STAT, 32'h2);
    pin_i = '0;
    cycles(3);
    rd("R4", OFS_STAT, 32'h6);
    wr(OFS_CLR, MASK);

    // R8 polarity rewrite on steady pins
    wr(OFS_POL, 32'h0);
    wr(OFS_POL, MASK);
    wr(OFS_POL, 32'h0);
    wr(OFS_POL, MASK);
    cycles(3);
    rd("R8", OFS_STAT, 0);

    // R9 summary interrupt gating
    wr(OFS_EN, 32'h2);
    chk("R9", "irq idle", 32'(irq_o), 0);
    pin_i = 27'h8;
    cycles(3);
    rd("R9", OFS_STAT, 32'h8);
    chk("R9", "irq disabled src", 32'(irq_o), 0);
    pin_i = 27'hA;
    cycles(3);
    chk("R9", "irq enabled src", 32'(irq_o), 1);
    wr(OFS_CLR, 32'h2);
    chk("R9", "irq after clear", 32'(irq_o), 0);

    // R7 edge event and clear collide on pin 5
    @(negedge clk_i); pin_i = 27'h2A;
    @(negedge clk_i);
    @(negedge clk_i); addr_i = OFS_CLR; wdata_i = 32'h20; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
    rd("R7", OFS_STAT, 32'h28);

    // R7 active level survives clear on pin 6
    wr(OFS_TRIG, MASK & ~32'h40);
    pin_i = 27'h6A;
    cycles(3);
    wr(OFS_CLR, 32'h40);
    rd("R7", OFS_STAT, 32'h68);

    // Randomised phase against the model
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk_i);
      if ($urandom_range(3) == 0) pin_i = pin_i ^ NP'($urandom & $urandom);
      addr_i  = addrs[$urandom_range(9)];
      wr_i    = ($urandom_range(2) == 0);
      wdata_i = (addr_i == OFS_CLR) ? ($urandom & $urandom) : $urandom;
      #1;
      chk("R2 R3 R5 R10", "rdata vs model", rdata_o, model_read(addr_i));
      chk("R9", "irq vs model", 32'(irq_o), 32'(|(m_stat & m_en)));
      chk("R2", "pin_out_o vs model", 32'(pin_out_o), m_out);
      chk("R2", "pin_oe_o vs model", 32'(pin_oe_o), m_oe);
    end
    @(negedge clk_i); wr_i = 1'b0;
    addr_i = OFS_STAT; #1;
    chk("R4 R6 R7", "final status", rdata_o, m_stat);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule